// File: doc/BRIEF.md
# Page Home Location Table

Each tile carries a small associative table that tells its core where the data of a virtual page lives. A page has exactly one home: the L1 cache of one tile. A load or store looks up its virtual page number. The answer says whether the access stays in the tile's own cache or goes to a remote home tile. A miss never guesses a location. It raises a miss request so that system software can pick a home, by default the first tile to touch the page, and write the mapping in through the fill port.

Pages that are only read may be entered as local replicas in many tiles at once, and reads that hit such an entry are served locally. A write that hits a replica raises a trap. Software then installs the owner tile over the replica, and after that every access goes to the owner. Once a page has an owner, its owner stays fixed until the whole table is cleared. A single-page invalidate drops one mapping. A clear-all command empties the table for lock acquire and for barrier-time page migration.

Top module: `page_home_map`

## Requirements
- R1: After reset the table is empty, `rsp_valid` is 0, and any lookup misses.
- R2: A lookup presented in cycle t is answered with `rsp_valid`=1 in cycle t+1. `rsp_valid` is 0 in any cycle that follows a cycle without a lookup.
- R3: A lookup that hits an owned entry returns `rsp_hit`=1 and the stored tile on `rsp_tile`. `rsp_local` is 1 exactly when that tile equals the parameter `LOCAL_TILE` (default 3), for reads and for writes.
- R4: A lookup that misses returns `rsp_hit`=0, `rsp_miss`=1, `rsp_tile`=0, and the looked-up page on `miss_vpn`. In every answer exactly one of `rsp_hit` and `rsp_miss` is 1.
- R5: A fill with `fill_ro`=1 makes a replica entry that records `LOCAL_TILE` whatever `fill_tile` holds. A read hitting it returns hit=1, local=1, tile=`LOCAL_TILE`, trap=0.
- R6: A write hitting a replica entry returns `rsp_trap`=1 with hit=1, local=0, miss=0.
- R7: A fill whose page matches a replica entry overwrites that entry in place and uses no new slot. After an owner fill (`fill_ro`=0), writes return the owner tile with no trap.
- R8: A fill whose page matches an owned entry is ignored, and the entry keeps its tile.
- R9: The table holds 16 pages. A fill of a page not present takes slots in round-robin order, so the 17th distinct page evicts the first one filled, and no other page is lost.
- R10: `inv_one` removes only the entry that matches `inv_vpn`.
- R11: `inv_all` empties the table in one cycle. A lookup in the same cycle misses, and a fill or single invalidate in the same cycle is discarded.
- R12: When `inv_one` and `fill_valid` are both asserted without `inv_all`, the invalidate is applied and the fill is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Page number looked up |
| lk_write | input | 1 | Lookup is for a store |
| fill_valid | input | 1 | Install a mapping |
| fill_vpn | input | VPN_W | Page number to install |
| fill_tile | input | TILE_W | Owner tile for the page |
| fill_ro | input | 1 | Install as a local read-only replica |
| inv_one | input | 1 | Drop the mapping of one page |
| inv_vpn | input | VPN_W | Page number to drop |
| inv_all | input | 1 | Drop every mapping |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_hit | output | 1 | Page found |
| rsp_local | output | 1 | Access is served by the own tile |
| rsp_tile | output | TILE_W | Home tile of the page |
| rsp_trap | output | 1 | Write to a replica page |
| rsp_miss | output | 1 | Mapping request for software |
| miss_vpn | output | VPN_W | Page number that missed |

## Verification
The hardest situation to reach from the ports is a wrap of the replacement pointer with a replica converted in place along the way. If that conversion took a new slot, the table would evict the wrong page only many fills later. The stimulus clears the table, enters a replica, converts it to owned, and then fills exactly fifteen more pages and one extra. The last fill must evict the converted page and no other. A full sweep of sixteen owned pages with computed tiles checks every slot for reads and writes. Collisions between the clear-all, the single invalidate, the fill and the lookup are driven in the same cycle to test the priority order.

// File: rtl/phm_pkg.sv
package phm_pkg;

  // table update chosen for one cycle; only one is applied
  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_FILL  = 2'd1,
    CMD_DROP  = 2'd2,
    CMD_CLEAR = 2'd3
  } upd_cmd_e;

  // clear-all beats single drop, which beats fill
  function automatic upd_cmd_e pick_cmd(input logic clr, input logic drop, input logic fill);
    if (clr)       return CMD_CLEAR;
    else if (drop) return CMD_DROP;
    else if (fill) return CMD_FILL;
    else           return CMD_NONE;
  endfunction

endpackage

// File: rtl/phm_match.sv
module phm_match #(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]            ent_v,
  input  logic [N-1:0][VPN_W-1:0] ent_vpn,
  input  logic [VPN_W-1:0]        key,
  output logic [N-1:0]            vec,
  output logic                    hit,
  output logic [IDX_W-1:0]        idx
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign vec[g] = ent_v[g] && (ent_vpn[g] == key);
  end

  assign hit = |vec;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (vec[i]) idx = idx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/phm_rr.sv
module phm_rr #(
  parameter int N = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             clr,
  output logic [IDX_W-1:0] ptr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (clr) ptr <= '0;
    else if (adv) ptr <= (int'(ptr) == N - 1) ? '0 : ptr + 1'b1;
  end

  assert_ptr_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) < N);

endmodule

// File: rtl/page_home_map.sv
module page_home_map
  import phm_pkg::*;
#(
  parameter int N          = 16,
  parameter int VPN_W      = 20,
  parameter int TILE_W     = 5,
  parameter int LOCAL_TILE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic              lk_write,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [TILE_W-1:0] fill_tile,
  input  logic              fill_ro,
  input  logic              inv_one,
  input  logic [VPN_W-1:0]  inv_vpn,
  input  logic              inv_all,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_local,
  output logic [TILE_W-1:0] rsp_tile,
  output logic              rsp_trap,
  output logic              rsp_miss,
  output logic [VPN_W-1:0]  miss_vpn
);

  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [TILE_W-1:0] HOME = TILE_W'(LOCAL_TILE);

  // table state
  logic [N-1:0]             tab_v;
  logic [N-1:0]             tab_ro;
  logic [N-1:0][VPN_W-1:0]  tab_vpn;
  logic [N-1:0][TILE_W-1:0] tab_tile;

  // named internal events
  logic [N-1:0]     l_vec, f_vec, d_vec;
  logic             l_hit, f_hit, d_hit;
  logic [IDX_W-1:0] l_idx, f_idx, d_idx;
  logic [IDX_W-1:0] victim;
  upd_cmd_e         cmd;
  logic             fill_alloc, fill_inplace, fill_blocked;
  logic [TILE_W-1:0] fill_tile_eff;
  logic             hit_n, trap_n, local_n;

  phm_match #(.N(N), .VPN_W(VPN_W)) u_lk_match (
    .ent_v(tab_v), .ent_vpn(tab_vpn), .key(lk_vpn),
    .vec(l_vec), .hit(l_hit), .idx(l_idx));

  phm_match #(.N(N), .VPN_W(VPN_W)) u_fill_match (
    .ent_v(tab_v), .ent_vpn(tab_vpn), .key(fill_vpn),
    .vec(f_vec), .hit(f_hit), .idx(f_idx));

  phm_match #(.N(N), .VPN_W(VPN_W)) u_drop_match (
    .ent_v(tab_v), .ent_vpn(tab_vpn), .key(inv_vpn),
    .vec(d_vec), .hit(d_hit), .idx(d_idx));

  assign cmd           = pick_cmd(inv_all, inv_one, fill_valid);
  assign fill_alloc    = (cmd == CMD_FILL) && !f_hit;
  assign fill_inplace  = (cmd == CMD_FILL) && f_hit && tab_ro[f_idx];
  assign fill_blocked  = (cmd == CMD_FILL) && f_hit && !tab_ro[f_idx];
  assign fill_tile_eff = fill_ro ? HOME : fill_tile;

  phm_rr #(.N(N)) u_rr (
    .clk(clk), .rst_n(rst_n),
    .adv(fill_alloc), .clr(cmd == CMD_CLEAR), .ptr(victim));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tab_v    <= '0;
      tab_ro   <= '0;
      tab_vpn  <= '0;
      tab_tile <= '0;
    end else begin
      unique case (cmd)
        CMD_CLEAR: tab_v <= '0;
        CMD_DROP:  if (d_hit) tab_v[d_idx] <= 1'b0;
        CMD_FILL: begin
          if (fill_alloc) begin
            tab_v[victim]    <= 1'b1;
            tab_ro[victim]   <= fill_ro;
            tab_vpn[victim]  <= fill_vpn;
            tab_tile[victim] <= fill_tile_eff;
          end else if (fill_inplace) begin
            tab_ro[f_idx]   <= fill_ro;
            tab_tile[f_idx] <= fill_tile_eff;
          end
        end
        default: ;
      endcase
    end
  end

  // lookup answer, registered
  assign hit_n   = lk_valid && l_hit && !inv_all;
  assign trap_n  = hit_n && lk_write && tab_ro[l_idx];
  assign local_n = hit_n && !trap_n && (tab_tile[l_idx] == HOME);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_local <= 1'b0;
      rsp_tile  <= '0;
      rsp_trap  <= 1'b0;
      rsp_miss  <= 1'b0;
      miss_vpn  <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= hit_n;
      rsp_local <= local_n;
      rsp_tile  <= hit_n ? tab_tile[l_idx] : '0;
      rsp_trap  <= trap_n;
      rsp_miss  <= lk_valid && !hit_n;
      if (lk_valid) miss_vpn <= lk_vpn;
    end
  end

  // assertions
  assert_answer_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  assert_no_spurious_answer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  assert_hit_xor_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit ^ rsp_miss));
  assert_trap_on_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trap |-> (rsp_hit && !rsp_local));
  assert_single_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(l_vec));
  assert_owner_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_blocked |=> ($stable(tab_tile) && $stable(tab_v) && $stable(tab_ro)));
  assert_clear_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_CLEAR) |=> (tab_v == '0));
  assert_clear_lookup_miss_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && inv_all) |=> (rsp_miss && !rsp_hit));
  assert_drop_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_one && fill_valid && !inv_all && !d_hit) |=> $stable(tab_v));

endmodule

// File: tb/page_home_map_tb.sv
module page_home_map_tb;

  localparam int VPN_W = 20;
  localparam int TILE_W = 5;
  localparam int LT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 0, lk_write = 0, fill_valid = 0, fill_ro = 0, inv_one = 0, inv_all = 0;
  logic [VPN_W-1:0] lk_vpn = '0, fill_vpn = '0, inv_vpn = '0;
  logic [TILE_W-1:0] fill_tile = '0;
  logic rsp_valid, rsp_hit, rsp_local, rsp_trap, rsp_miss;
  logic [TILE_W-1:0] rsp_tile;
  logic [VPN_W-1:0] miss_vpn;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  page_home_map u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_write(lk_write),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_tile(fill_tile), .fill_ro(fill_ro),
    .inv_one(inv_one), .inv_vpn(inv_vpn), .inv_all(inv_all),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_local(rsp_local), .rsp_tile(rsp_tile),
    .rsp_trap(rsp_trap), .rsp_miss(rsp_miss), .miss_vpn(miss_vpn));

  function automatic logic [VPN_W-1:0] pg(input int k);
    return VPN_W'(32'h100 + k * 37);
  endfunction
  function automatic logic [TILE_W-1:0] tl(input int k);
    return TILE_W'((k * 11 + 2) % 32);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // lookup and check the answer one cycle later
  task automatic look(input logic [VPN_W-1:0] v, input logic wr, input bit e_hit,
                      input int e_tile, input bit e_loc, input bit e_trap, input string req);
    @(negedge clk);
    lk_valid = 1; lk_vpn = v; lk_write = wr;
    @(negedge clk);
    lk_valid = 0; lk_write = 0;
    chk(req, "valid", rsp_valid, 1);
    chk(req, "hit", rsp_hit, e_hit);
    chk(req, "miss", rsp_miss, !e_hit);
    chk(req, "tile", rsp_tile, e_hit ? e_tile : 0);
    chk(req, "local", rsp_local, e_loc);
    chk(req, "trap", rsp_trap, e_trap);
    if (!e_hit) chk(req, "miss_vpn", miss_vpn, v);
  endtask

  task automatic fill(input logic [VPN_W-1:0] v, input int t, input logic ro);
    @(negedge clk);
    fill_valid = 1; fill_vpn = v; fill_tile = TILE_W'(t); fill_ro = ro;
    @(negedge clk);
    fill_valid = 0; fill_ro = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "reset valid", rsp_valid, 0);
    look(pg(0), 0, 0, 0, 0, 0, "R1");
    @(negedge clk);
    chk("R2", "idle valid", rsp_valid, 0);

    // sweep: sixteen owned pages, reads and writes
    for (int k = 0; k < 16; k++) fill(pg(k), tl(k), 0);
    for (int k = 0; k < 16; k++) begin
      look(pg(k), 0, 1, tl(k), tl(k) == LT, 0, "R3");
      look(pg(k), 1, 1, tl(k), tl(k) == LT, 0, "R3");
    end
    look(pg(40), 0, 0, 0, 0, 0, "R4");

    // 17th page evicts the first
    fill(pg(16), 9, 0);
    look(pg(0), 0, 0, 0, 0, 0, "R9");
    for (int k = 1; k < 17; k++) look(pg(k), 0, 1, (k == 16) ? 9 : tl(k), ((k == 16) ? 9 : tl(k)) == LT, 0, "R9");

    // owned page keeps its tile
    fill(pg(1), 20, 0);
    look(pg(1), 1, 1, tl(1), 0, 0, "R8");
    fill(pg(1), 0, 1);
    look(pg(1), 1, 1, tl(1), 0, 0, "R8");

    // clear-all with a same-cycle lookup
    @(negedge clk);
    inv_all = 1; lk_valid = 1; lk_vpn = pg(2); lk_write = 0;
    @(negedge clk);
    inv_all = 0; lk_valid = 0;
    chk("R11", "same-cycle hit", rsp_hit, 0);
    chk("R11", "same-cycle miss", rsp_miss, 1);
    look(pg(5), 0, 0, 0, 0, 0, "R11");
    look(pg(16), 0, 0, 0, 0, 0, "R11");

    // replica, trap, owner install in place
    fill(VPN_W'(32'h9000), 20, 1);
    look(VPN_W'(32'h9000), 0, 1, LT, 1, 0, "R5");
    look(VPN_W'(32'h9000), 1, 1, LT, 0, 1, "R6");
    fill(VPN_W'(32'h9000), 7, 0);
    look(VPN_W'(32'h9000), 1, 1, 7, 0, 0, "R7");
    look(VPN_W'(32'h9000), 0, 1, 7, 0, 0, "R7");
    for (int k = 0; k < 15; k++) fill(VPN_W'(32'hA000 + k), k, 0);
    look(VPN_W'(32'h9000), 0, 1, 7, 0, 0, "R7");
    fill(VPN_W'(32'hB000), 12, 0);
    look(VPN_W'(32'h9000), 0, 0, 0, 0, 0, "R7");
    look(VPN_W'(32'hA000), 0, 1, 0, 0, 0, "R7");
    look(VPN_W'(32'hB000), 0, 1, 12, 0, 0, "R9");

    // single invalidate
    @(negedge clk);
    inv_one = 1; inv_vpn = VPN_W'(32'hA003);
    @(negedge clk);
    inv_one = 0;
    look(VPN_W'(32'hA003), 0, 0, 0, 0, 0, "R10");
    look(VPN_W'(32'hA004), 0, 1, 4, 0, 0, "R10");
    look(VPN_W'(32'hA003 + 0), 1, 0, 0, 0, 0, "R10");

    // drop and fill together
    @(negedge clk);
    inv_one = 1; inv_vpn = VPN_W'(32'hA005);
    fill_valid = 1; fill_vpn = VPN_W'(32'hC000); fill_tile = 3; fill_ro = 0;
    @(negedge clk);
    inv_one = 0; fill_valid = 0;
    look(VPN_W'(32'hA005), 0, 0, 0, 0, 0, "R12");
    look(VPN_W'(32'hC000), 0, 0, 0, 0, 0, "R12");
    look(VPN_W'(32'hA006), 0, 1, 6, 0, 0, "R12");

    // clear-all and fill together
    @(negedge clk);
    inv_all = 1;
    fill_valid = 1; fill_vpn = VPN_W'(32'hD000); fill_tile = 3; fill_ro = 0;
    @(negedge clk);
    inv_all = 0; fill_valid = 0;
    look(VPN_W'(32'hD000), 0, 0, 0, 0, 0, "R11");
    look(VPN_W'(32'hA006), 0, 0, 0, 0, 0, "R11");
    fill(VPN_W'(32'hD000), 3, 0);
    look(VPN_W'(32'hD000), 0, 1, 3, 1, 0, "R3");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule